// File: doc/BRIEF.md
# Microsecond Countdown Timer Channel

This block is one countdown timer channel driven through a small word-addressed register interface. Software writes a control word that holds an enable bit, a mode bit and a 28-bit preset. The counter then steps down once per microsecond. A free-running prescaler turns the core clock into a one-cycle tick every `CLK_PER_US` cycles. A source-select register chooses whether that tick reaches the counter.

When the count runs out, the channel latches an interrupt flag and drives a one-cycle expiration pulse that neighbouring logic, such as a watchdog, can count. In periodic mode the counter reloads the preset and keeps running. In one-shot mode it drops its own enable bit and goes idle. The interrupt line is the latched flag qualified by the enable bit. Software clears the flag by writing a one to the flag bit of the status word.

The sequencing lives in a three-state machine:
- `ST_IDLE` means stopped.
- `ST_RUN` means counting.
- `ST_PAUSE` means armed while the selected time base is not the microsecond tick.

Transitions:
- `ST_IDLE` → `ST_RUN` on a control write with enable set.
- `ST_RUN` → `ST_RUN` on a periodic expiry (reload), or on a control write with enable set (restart).
- `ST_RUN` → `ST_IDLE` on a one-shot expiry, or on a control write with enable clear.
- `ST_RUN` → `ST_PAUSE` when the source select becomes non-zero.
- `ST_PAUSE` → `ST_RUN` when it returns to zero.
- `ST_PAUSE` → `ST_IDLE` on a stop write.

Top module: `usec_countdown_timer`

## Requirements
- R1: After reset, all three registers read zero, and `irq` and `expire_pulse` are low.
- R2: Register map:
  - Offset 0x0 is the control word. Bit 31 is enable, bit 30 is periodic mode, and bits 27:0 are the preset. Bits 29:28 read as zero.
  - Offset 0x4 is the status word. Bit 30 is the interrupt flag.
  - Offset 0x8 is the source select, in bits 3:0.
  - Any other offset reads zero.
- R3: The prescaler produces a one-cycle tick every `CLK_PER_US` clock cycles, free-running from reset.
- R4: A control write with bit 31 set loads the preset from that write. On the tick where the count reaches zero, `expire_pulse` is high for exactly one cycle. For preset N ≥ 1, the first pulse appears between (N-1)·`CLK_PER_US`+1 and N·`CLK_PER_US` cycles after the write edge.
- R5: An expiry sets status bit 30. Writing 1 to status bit 30 clears it, and writing 0 leaves it set. An expiry in the same cycle as the clear wins.
- R6: In one-shot mode (bit 30 = 0), the expiry clears control bit 31 and no further pulses follow.
- R7: In periodic mode, pulses repeat every N·`CLK_PER_US` cycles and the enable stays set. A preset of 0 behaves as a preset of 1.
- R8: While the source select is non-zero the count is frozen and no expiry occurs. Writing 0 back resumes counting from the held value.
- R9: A control write with bit 31 clear stops the channel, and no further pulses occur.
- R10: `irq` is high only while both the flag and the enable bit are set. Once enable is clear, `irq` is low even if the flag still reads 1.
- R11: A control write with bit 31 set while the channel is running restarts it from the newly written preset, with the first pulse timed as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: flag qualified by enable |
| expire_pulse | output | 1 | One-cycle pulse on each expiry |

## Verification
The assertions assume that `CLK_PER_US` is at least 2, so that two ticks, and therefore two expiries, can never fall on adjacent cycles. The bench builds the channel with four cycles per microsecond. The single-cycle checks on the tick and on the expiry pulse also rely on register writes arriving as single-cycle strobes. The one-shot disarm check allows for a control write landing on the expiry edge, because such a write takes priority over the disarm. The bench drives every write for exactly one cycle, away from the clock edge, and issues at most one write per cycle.

// File: rtl/usct_pkg.sv
package usct_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned PER_BIT  = 30;
    localparam int unsigned FLAG_BIT = 30;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_SRC  = 4'h8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } run_state_e;
endpackage

// File: rtl/usct_prescaler.sv
module usct_prescaler #(
    parameter int unsigned DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_divide
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] phase;

            assign tick = (phase == LAST);

            always_ff @(posedge clk) begin
                if (!rst_n)    phase <= '0;
                else if (tick) phase <= '0;
                else           phase <= phase + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/usct_regs.sv
module usct_regs
    import usct_pkg::*;
#(
    parameter int unsigned PRESET_W = 28,
    parameter int unsigned SRC_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                expire_evt,
    input  logic                oneshot_done,
    output logic [DATA_W-1:0]   rdata,
    output logic                ctrl_en,
    output logic                ctrl_per,
    output logic [PRESET_W-1:0] ctrl_preset,
    output logic [SRC_W-1:0]    src_sel,
    output logic                flag,
    output logic                start_req,
    output logic                stop_req
);
    logic wr_ctrl, wr_stat, wr_src;
    logic unused_wdata;

    assign unused_wdata = ^wdata;
    assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
    assign wr_stat   = wr_en && (addr == OFS_STAT);
    assign wr_src    = wr_en && (addr == OFS_SRC);
    assign start_req = wr_ctrl && wdata[EN_BIT];
    assign stop_req  = wr_ctrl && !wdata[EN_BIT];

    // Control word: a software write outranks the one-shot self-disarm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en     <= 1'b0;
            ctrl_per    <= 1'b0;
            ctrl_preset <= '0;
        end else if (wr_ctrl) begin
            ctrl_en     <= wdata[EN_BIT];
            ctrl_per    <= wdata[PER_BIT];
            ctrl_preset <= wdata[PRESET_W-1:0];
        end else if (oneshot_done) begin
            ctrl_en     <= 1'b0;
        end
    end

    // Interrupt flag: set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (expire_evt)                 flag <= 1'b1;
        else if (wr_stat && wdata[FLAG_BIT]) flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      src_sel <= '0;
        else if (wr_src) src_sel <= wdata[SRC_W-1:0];
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[EN_BIT]         = ctrl_en;
                rdata[PER_BIT]        = ctrl_per;
                rdata[PRESET_W-1:0]   = ctrl_preset;
            end
            OFS_STAT: rdata[FLAG_BIT] = flag;
            OFS_SRC:  rdata[SRC_W-1:0] = src_sel;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/usct_fsm.sv
module usct_fsm
    import usct_pkg::*;
#(
    parameter int unsigned PRESET_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                src_ok,
    input  logic                start_req,
    input  logic                stop_req,
    input  logic [PRESET_W-1:0] start_preset,
    input  logic                ctrl_per,
    input  logic [PRESET_W-1:0] ctrl_preset,
    output logic                expire_evt,
    output logic                oneshot_done,
    output logic                expire_pulse
);
    run_state_e          state, nxt;
    logic [PRESET_W-1:0] count;
    logic                do_load, do_reload, do_dec, do_clear;
    logic                last_step;

    assign last_step = (count <= PRESET_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and per-cycle decisions
    always_comb begin
        nxt          = state;
        do_load      = 1'b0;
        do_reload    = 1'b0;
        do_dec       = 1'b0;
        do_clear     = 1'b0;
        expire_evt   = 1'b0;
        oneshot_done = 1'b0;
        if (start_req) begin
            nxt     = ST_RUN;
            do_load = 1'b1;
        end else if (stop_req) begin
            nxt      = ST_IDLE;
            do_clear = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_RUN: begin
                    if (!src_ok) begin
                        nxt = ST_PAUSE;
                    end else if (tick) begin
                        if (last_step) begin
                            expire_evt = 1'b1;
                            if (ctrl_per) begin
                                do_reload = 1'b1;
                            end else begin
                                oneshot_done = 1'b1;
                                nxt          = ST_IDLE;
                            end
                        end else begin
                            do_dec = 1'b1;
                        end
                    end
                end
                ST_PAUSE: if (src_ok) nxt = ST_RUN;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // Counter and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count        <= '0;
            expire_pulse <= 1'b0;
        end else begin
            expire_pulse <= expire_evt;
            if (do_load)        count <= start_preset;
            else if (do_reload) count <= ctrl_preset;
            else if (do_dec)    count <= count - 1'b1;
            else if (do_clear)  count <= '0;
        end
    end
endmodule

// File: rtl/usec_countdown_timer.sv
module usec_countdown_timer
    import usct_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 125,
    parameter int unsigned PRESET_W   = 28,
    parameter int unsigned SRC_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              expire_pulse
);
    logic                tick;
    logic                expire_evt, oneshot_done;
    logic                ctrl_en, ctrl_per, irq_flag;
    logic [PRESET_W-1:0] ctrl_preset;
    logic [SRC_W-1:0]    src_sel;
    logic                start_req, stop_req, ctrl_wr, src_ok;

    assign src_ok  = (src_sel == '0);
    assign ctrl_wr = start_req | stop_req;
    assign irq     = irq_flag & ctrl_en;

    usct_prescaler #(.DIV(CLK_PER_US)) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    usct_regs #(.PRESET_W(PRESET_W), .SRC_W(SRC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .expire_evt  (expire_evt),
        .oneshot_done(oneshot_done),
        .rdata       (bus_rdata),
        .ctrl_en     (ctrl_en),
        .ctrl_per    (ctrl_per),
        .ctrl_preset (ctrl_preset),
        .src_sel     (src_sel),
        .flag        (irq_flag),
        .start_req   (start_req),
        .stop_req    (stop_req)
    );

    usct_fsm #(.PRESET_W(PRESET_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .src_ok      (src_ok),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .start_preset(bus_wdata[PRESET_W-1:0]),
        .ctrl_per    (ctrl_per),
        .ctrl_preset (ctrl_preset),
        .expire_evt  (expire_evt),
        .oneshot_done(oneshot_done),
        .expire_pulse(expire_pulse)
    );
endmodule

// File: rtl/usct_chk.sv
module usct_chk #(
    parameter int unsigned DIV   = 125,
    parameter int unsigned SRC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             expire_pulse,
    input logic             flag,
    input logic             ctrl_en,
    input logic             ctrl_per,
    input logic             ctrl_wr,
    input logic [SRC_W-1:0] src_sel,
    input logic             irq
);
    localparam bit MULTI = (DIV > 1);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (MULTI && tick) |=> !tick);                                         // R3
    AST_EXPIRE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> $past(tick));                                      // R4
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (MULTI && expire_pulse) |=> !expire_pulse);                         // R4
    AST_FLAG_WITH_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> flag);                                             // R5
    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_pulse && !ctrl_per && !$past(ctrl_wr)) |-> !ctrl_en);       // R6
    AST_SRC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel != '0) |=> !expire_pulse);                                 // R8
    AST_IRQ_LOW_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_en) |-> !irq);                                           // R10
endmodule

bind usec_countdown_timer usct_chk #(.DIV(CLK_PER_US), .SRC_W(SRC_W)) u_usct_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .expire_pulse(expire_pulse),
    .flag        (irq_flag),
    .ctrl_en     (ctrl_en),
    .ctrl_per    (ctrl_per),
    .ctrl_wr     (ctrl_wr),
    .src_sel     (src_sel),
    .irq         (irq)
);

// File: tb/test_usec_countdown_timer.sv
module test_usec_countdown_timer;
    import usct_pkg::*;

    localparam int P  = 4;
    localparam int NV = 6;
    // stimulus: preset, periodic flag; expected: interval in cycles
    localparam int T_PRE [NV] = '{3, 1, 0, 10, 6, 2};
    localparam int T_PER [NV] = '{1, 1, 1, 0,  1, 0};
    localparam int T_IVL [NV] = '{12, 4, 4, 40, 24, 8};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, expire_pulse;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usec_countdown_timer #(.CLK_PER_US(P)) i_usec_countdown_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .expire_pulse(expire_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_pulse(input int lim, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!expire_pulse && k < lim);
        if (!expire_pulse) k = 0;
    endtask

    task automatic quiet(input int n, output int seen);
        seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (expire_pulse) seen++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired before completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int k, seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(OFS_CTRL, d); chk(d == 0, "R1 ctrl reset", d, 0);
        rd(OFS_STAT, d); chk(d == 0, "R1 status reset", d, 0);
        rd(OFS_SRC, d);  chk(d == 0, "R1 source reset", d, 0);
        chk(!irq && !expire_pulse, "R1 outputs low", {irq, expire_pulse}, 0);

        // R2 register map
        wr(OFS_CTRL, 32'h7000_0005);
        rd(OFS_CTRL, d); chk(d == 32'h4000_0005, "R2 ctrl readback", d, 32'h4000_0005);
        rd(4'hC, d);     chk(d == 0, "R2 unmapped reads zero", d, 0);
        wr(OFS_SRC, 32'hFFFF_FFF3);
        rd(OFS_SRC, d);  chk(d == 32'h3, "R2 source field", d, 3);
        wr(OFS_SRC, 0);
        wr(OFS_CTRL, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            int ne;
            ne = (T_PRE[i] == 0) ? 1 : T_PRE[i];
            wr(OFS_CTRL, {1'b1, (T_PER[i] != 0), 2'b00, 28'(T_PRE[i])});
            wait_pulse(T_IVL[i] + 8, k);
            chk(k >= (ne - 1) * P + 1 && k <= ne * P, "R4 first expiry window", k, ne * P);
            rd(OFS_STAT, d); chk(d[30], "R5 flag set on expiry", d, 32'h4000_0000);
            if (T_PER[i] != 0) begin
                wait_pulse(T_IVL[i] + 8, k);
                chk(k == T_IVL[i], "R7 periodic interval (R3 tick rate)", k, T_IVL[i]);
                rd(OFS_CTRL, d); chk(d[31], "R7 enable kept", d[31], 1);
            end else begin
                rd(OFS_CTRL, d); chk(!d[31], "R6 one-shot disarms", d[31], 0);
                quiet(3 * T_IVL[i], seen); chk(seen == 0, "R6 no further expiry", seen, 0);
            end
            wr(OFS_CTRL, 0);
            wr(OFS_STAT, 32'h4000_0000);
        end

        // R5 write-one-to-clear, R10 irq gating after one-shot
        wr(OFS_CTRL, 32'h0000_0001);
        wr(OFS_CTRL, 32'h8000_0001);
        wait_pulse(20, k);
        chk(k != 0, "R6 one-shot fires", k, 1);
        @(negedge clk);
        rd(OFS_STAT, d); chk(d[30] && !irq, "R10 flag set, irq low when disarmed", {irq, d[30]}, 1);
        wr(OFS_STAT, 0);
        rd(OFS_STAT, d); chk(d[30], "R5 writing zero keeps flag", d, 32'h4000_0000);
        wr(OFS_STAT, 32'h4000_0000);
        rd(OFS_STAT, d); chk(d == 0, "R5 write one clears flag", d, 0);

        // R10 irq while armed, R9 stop
        wr(OFS_CTRL, 32'hC000_0002);
        wait_pulse(20, k);
        chk(irq, "R10 irq high while armed with flag", irq, 1);
        wr(OFS_CTRL, 0);
        rd(OFS_STAT, d);
        chk(!irq && d[30], "R10 stop drops irq, flag kept", {irq, d[30]}, 1);
        quiet(100, seen); chk(seen == 0, "R9 stopped channel silent", seen, 0);
        wr(OFS_STAT, 32'h4000_0000);

        // R8 freeze by source select
        wr(OFS_CTRL, 32'hC000_0005);
        wr(OFS_SRC, 32'h1);
        quiet(100, seen); chk(seen == 0, "R8 frozen while source nonzero", seen, 0);
        rd(OFS_STAT, d); chk(d == 0, "R8 no flag while frozen", d, 0);
        wr(OFS_SRC, 0);
        wait_pulse(5 * P + 4, k);
        chk(k >= 1 && k <= 5 * P, "R8 resumes from held count", k, 5 * P);
        wr(OFS_CTRL, 0);
        wr(OFS_STAT, 32'h4000_0000);

        // R11 restart with new preset while running
        wr(OFS_CTRL, 32'hC000_0014);
        quiet(30, seen); chk(seen == 0, "R11 long preset not yet expired", seen, 0);
        wr(OFS_CTRL, 32'hC000_0002);
        wait_pulse(40, k);
        chk(k >= P + 1 && k <= 2 * P, "R11 restart timing", k, 2 * P);
        wr(OFS_CTRL, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule